// File: doc/BRIEF.md
# Parallel-Prefix Round-Robin Arbiter

This block shares one resource among `N` requesters. Each cycle it looks at the request vector and picks one request. The search starts at the requester that currently holds top priority and wraps around past the highest index. The pick is reported as a one-hot grant vector, together with a valid flag.

Fairness comes from a rotating priority. When a grant is taken, the requester that won drops to the lowest priority and its upper neighbour moves to the top. The priority position is stored as a thermometer mask, in which every index at or above the top-priority index is set.

The search does not use a ripple chain. Two first-one finders, one over the masked requests and one over the raw requests, are built on a Kogge-Stone style OR-prefix tree, so the logic depth grows with log2(N). The same tree turns a grant into the next thermometer mask. The advance enable lets the consumer decide whether a grant that was shown on the outputs actually rotates the priority.

Top module: `pp_rr_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set, and `gnt_vld_o` is high exactly when `gnt_o` is nonzero.
- R2: A bit of `gnt_o` is set only where the same bit of `req_i` is set.
- R3: `gnt_vld_o` is high in a cycle exactly when at least one bit of `req_i` is high; the grant is combinational in the current requests.
- R4: With no request asserted, `gnt_o` is all zeros and the priority position does not change, even if `adv_i` is high.
- R5: The granted index is the first asserted request found by scanning upward from the top-priority index p (p, p+1, …, N-1), then wrapping to 0, 1, …, p-1.
- R6: On a rising clock edge with `gnt_vld_o` and `adv_i` both high, and granted index g, the top-priority index becomes (g+1) mod N.
- R7: On a rising clock edge with `adv_i` low, the top-priority index is unchanged.
- R8: After reset, index 0 holds top priority, and the stored mask is all ones (thermometer code with every bit at or above the top index set).
- R9: With every request held high and `adv_i` high, each input receives exactly one grant in every window of N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N | Request vector, bit i = requester i |
| adv_i | input | 1 | Advance enable: rotate priority after a grant on this edge |
| gnt_o | output | N | One-hot grant |
| gnt_vld_o | output | 1 | A grant is being issued this cycle |

## Verification
Some properties are checked by the assertions on every cycle:
- the grant is one-hot and lies inside the requests, with a valid flag that matches;
- the stored mask stays in thermometer code and is never empty;
- the mask holds when no grant is taken;
- after a taken grant, the winner sits below the new top priority.

Other behaviour is shown only by the bench's scenarios:
- the exact wrap-around order of the search;
- the (g+1) mod N pointer value after an edge at a boundary index;
- the equal share of grants per N-cycle window under full load.

The bench shows these by comparing against an integer-pointer model over near-exhaustive request sweeps on a five-input arbiter.

// File: rtl/rra_pkg.sv
package rra_pkg;

  // Number of prefix levels needed to span n bits (at least one level).
  function automatic int unsigned prefix_levels(input int unsigned n);
    int unsigned lv;
    lv = 0;
    while ((1 << lv) < n) lv++;
    return (lv == 0) ? 1 : lv;
  endfunction

  // Distance covered by prefix level l.
  function automatic int unsigned level_span(input int unsigned l);
    return 1 << l;
  endfunction

endpackage

// File: rtl/rra_prefix_or.sv
// Kogge-Stone style inclusive OR prefix: incl_o[i] = |vec_i[i:0].
module rra_prefix_or #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] incl_o
);
  localparam int unsigned LV = rra_pkg::prefix_levels(N);

  logic [N-1:0] stage [LV+1];

  assign stage[0] = vec_i;

  generate
    for (genvar l = 0; l < LV; l++) begin : g_lvl
      localparam int unsigned SPAN = rra_pkg::level_span(l);
      assign stage[l+1] = stage[l] | (stage[l] << SPAN);
    end
  endgenerate

  assign incl_o = stage[LV];
endmodule

// File: rtl/rra_first_one.sv
// Lowest set bit of vec_i as a one-hot pick, through a log-depth prefix.
module rra_first_one #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] pick_o,
  output logic         any_o
);
  logic [N-1:0] incl;
  logic [N-1:0] below;   // some lower bit is set

  rra_prefix_or #(.N(N)) prefix_i (
    .vec_i  (vec_i),
    .incl_o (incl)
  );

  assign below  = {incl[N-2:0], 1'b0};
  assign pick_o = vec_i & ~below;
  assign any_o  = incl[N-1];

  always_comb begin
    AST_PICK_ONEHOT: assert ($onehot0(pick_o)) else $error("pick not one-hot"); // R1
    AST_PICK_INSIDE: assert ((pick_o & ~vec_i) == '0) else $error("pick outside vector"); // R2
  end
endmodule

// File: rtl/rra_thermo_ptr.sv
// Thermometer priority mask: bits at or above the top-priority index are set.
module rra_thermo_ptr #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] gnt_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] gnt_incl;
  logic [N-1:0] mask_next;
  logic [N-1:0] mask_q;

  rra_prefix_or #(.N(N)) next_i (
    .vec_i  (gnt_i),
    .incl_o (gnt_incl)
  );

  // Bits strictly above the winner; a win at the top index wraps to all ones.
  assign mask_next = gnt_i[N-1] ? '1 : {gnt_incl[N-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '1;
    else if (load_i) mask_q <= mask_next;
  end

  assign mask_o = mask_q;

  AST_MASK_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q << 1) & ~mask_q) == '0) else $error("mask not thermometer"); // R8
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q != '0) else $error("mask empty"); // R8
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mask_q)) else $error("mask moved without load"); // R7
  AST_WINNER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !gnt_i[N-1]) |=> ((mask_q & $past(gnt_i)) == '0)) else $error("winner kept priority"); // R6
  AST_NEIGHBOUR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !gnt_i[N-1]) |=> ((mask_q & ($past(gnt_i) << 1)) != '0)) else $error("neighbour not promoted"); // R6
endmodule

// File: rtl/pp_rr_arbiter.sv
module pp_rr_arbiter #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o,
  output logic         gnt_vld_o
);
  logic [N-1:0] prio_mask;
  logic [N-1:0] req_masked;
  logic [N-1:0] pick_hi;
  logic [N-1:0] pick_all;
  logic         any_hi;
  logic         any_all;
  logic         take_grant;

  assign req_masked = req_i & prio_mask;

  rra_first_one #(.N(N)) hi_i (
    .vec_i  (req_masked),
    .pick_o (pick_hi),
    .any_o  (any_hi)
  );

  rra_first_one #(.N(N)) all_i (
    .vec_i  (req_i),
    .pick_o (pick_all),
    .any_o  (any_all)
  );

  assign gnt_o      = any_hi ? pick_hi : pick_all;
  assign gnt_vld_o  = any_all;
  assign take_grant = any_all & adv_i;

  rra_thermo_ptr #(.N(N)) ptr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (take_grant),
    .gnt_i  (gnt_o),
    .mask_o (prio_mask)
  );

  initial begin
    AST_N_RANGE: assert (N >= 2) else $error("N must be at least 2"); // R1
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o) && (gnt_vld_o == (gnt_o != '0))) else $error("grant shape"); // R1
  AST_GNT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0) else $error("grant without request"); // R2
  AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o == (req_i != '0)) else $error("valid mismatch"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> $stable(prio_mask)) else $error("pointer moved while idle"); // R4
endmodule

// File: tb/pp_rr_arbiter_tb.sv
module pp_rr_arbiter_tb_top;
  localparam int NB = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] req = '0;
  logic          adv = 1'b0;
  logic [NB-1:0] gnt;
  logic          vld;

  int total = 0;
  int bad   = 0;
  int ptr   = 0;     // reference top-priority index
  int win_cnt [NB];

  always #5 clk = ~clk;

  pp_rr_arbiter #(.N(NB)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .adv_i     (adv),
    .gnt_o     (gnt),
    .gnt_vld_o (vld)
  );

  function automatic int ref_pick(input logic [NB-1:0] r, input int p);
    for (int k = 0; k < NB; k++) begin
      if (r[(p + k) % NB]) return (p + k) % NB;
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at negedge, check the combinational outputs, then advance the model
  // to the state the coming rising edge produces.
  task automatic step(input logic [NB-1:0] r, input logic a, input string tag);
    int e;
    logic [NB-1:0] eg;
    @(negedge clk);
    req = r;
    adv = a;
    #1;
    e  = ref_pick(r, ptr);
    eg = (e < 0) ? '0 : NB'(1 << e);
    chk(gnt == eg, tag, int'(gnt), int'(eg));
    chk(vld == (e >= 0), {tag, " R3 valid"}, int'(vld), int'(e >= 0));
    if (e >= 0 && a) ptr = (e + 1) % NB;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    // Reset state: no requests, no grant (R3, R4).
    #12;
    chk(gnt == '0, "R4 reset grant", int'(gnt), 0);
    chk(vld == 1'b0, "R3 reset valid", int'(vld), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: index 0 on top after reset; R7: no advance keeps it there.
    for (int i = 0; i < 3; i++) step('1, 1'b0, "R8 R7 hold");

    // R6: walk the pointer across the top-index boundary.
    for (int i = 0; i < 2 * NB; i++) step(NB'(5'b10001), 1'b1, "R6 wrap");

    // R4: idle cycles with advance high leave the pointer alone.
    step('1, 1'b1, "R6 set");
    for (int i = 0; i < 3; i++) step('0, 1'b1, "R4 idle");
    step('1, 1'b0, "R4 pointer kept");

    // R5/R6/R7: sweep every request pattern against changing pointers.
    for (int k = 0; k < 3 * NB * (1 << NB); k++) begin
      step(NB'((k * 11 + k / 32) % (1 << NB)), (k % 4) != 3, "R5 R6 R7 sweep");
    end

    // R1/R2: single requests at every index.
    for (int i = 0; i < NB; i++) step(NB'(1 << i), 1'b1, "R1 R2 single");

    // R9: full load, each input wins once per NB-cycle window.
    for (int w = 0; w < 4; w++) begin
      for (int i = 0; i < NB; i++) win_cnt[i] = 0;
      for (int c = 0; c < NB; c++) begin
        step('1, 1'b1, "R9 full load");
        for (int i = 0; i < NB; i++) if (gnt[i]) win_cnt[i]++;
      end
      for (int i = 0; i < NB; i++) chk(win_cnt[i] == 1, "R9 share", win_cnt[i], 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule